// File: doc/BRIEF.md
# PIO Timing to Clock Converter

This block turns the nanosecond timing of a programmed-I/O transfer mode into counts of the bus clock, for both drives that share one channel. For each drive it takes an address setup time, an active (strobe) time and a full cycle time. It also takes one common bus frequency in MHz and a flag per drive that says whether the drive is fitted. From these it produces three clock counts per drive, each held within the range its field can encode: address setup, active pulse and recovery.

It also packs the active and recovery counts into one timing byte per drive, as the cycle generator expects them. Because both drives on a channel must use one address setup value, it gives the larger of the two address counts as a shared value.

A one-cycle `start` pulse samples all inputs. One clock later the results appear together with a one-cycle `done` pulse. They then stay fixed, whatever the inputs do, until the next `start`. The block is meant to be used again each time a drive's mode is chosen, and the caller copies the results into the timing registers.

Top module: `pio_clock_conv`

## Requirements
- R1: After reset, `done` is 0 and each drive reports address 1, active 1, recovery 2, timing byte 0x00. The shared address is 1.
- R2: A time of t ns at a bus of m MHz converts to ceil(t·m/1000) clocks, computed as (t·m+999)/1000 in integer division.
- R3: Recovery in ns is cycle minus setup minus active. It is converted after the subtraction, and a difference of zero or less counts as 0 ns.
- R4: Each address count is limited to the range 1 to 4 clocks.
- R5: Each active count is limited to the range 1 to 16 clocks.
- R6: Each recovery count is limited to the range 2 to 17 clocks.
- R7: For a drive whose present flag is 0, the result is address 1, active 1 and recovery 2, whatever its times are.
- R8: The timing byte of drive d sits at `cycle_byte[8d+7:8d]`. It holds active−1 in bits 7:4 and recovery−2 in bits 3:0.
- R9: `shared_addr` equals the larger of the two drives' address counts. An absent drive counts as 1.
- R10: A `start` sampled at a clock edge puts its results on the outputs after that edge and raises `done` for exactly one cycle. Without `start`, no input change alters any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample inputs and convert |
| bus_mhz | input | MHZ_W | Bus clock frequency in MHz |
| present | input | 2 | Drive fitted, one bit per drive |
| setup_ns | input | 2·NS_W | Address setup time per drive, drive d at [d·NS_W +: NS_W] |
| active_ns | input | 2·NS_W | Active pulse time per drive |
| cycle_ns | input | 2·NS_W | Total cycle time per drive |
| done | output | 1 | One-cycle pulse: new results valid |
| addr_clk | output | 6 | Address clocks, 3 bits per drive |
| act_clk | output | 10 | Active clocks, 5 bits per drive |
| rec_clk | output | 10 | Recovery clocks, 5 bits per drive |
| cycle_byte | output | 16 | Packed timing byte per drive |
| shared_addr | output | 3 | Address clocks shared by both drives |

## Verification
All results, including `done`, are due exactly one clock after the edge that samples `start`. None appears earlier, and none changes at any later edge without a new `start`. The bench updates its reference at the same edge as the design and compares every output on the falling edge of every cycle, so each result is checked in the cycle it becomes due and in every cycle it is meant to be held. Input changes made with `start` low are therefore caught at once if they leak through. A few directed vectors are also checked against hand-computed constants.

// File: rtl/pio_clock_conv.sv
module pio_clock_conv #(
  parameter int NS_W  = 10,
  parameter int MHZ_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MHZ_W-1:0]    bus_mhz,
  input  logic [1:0]          present,
  input  logic [2*NS_W-1:0]   setup_ns,
  input  logic [2*NS_W-1:0]   active_ns,
  input  logic [2*NS_W-1:0]   cycle_ns,
  output logic                done,
  output logic [5:0]          addr_clk,
  output logic [9:0]          act_clk,
  output logic [9:0]          rec_clk,
  output logic [15:0]         cycle_byte,
  output logic [2:0]          shared_addr
);
  localparam int PW = NS_W + MHZ_W + 1;
  typedef logic [PW-1:0] wide_t;

  function automatic wide_t ns_to_clk(input logic [NS_W-1:0] ns, input logic [MHZ_W-1:0] mhz);
    return (wide_t'(ns) * wide_t'(mhz) + wide_t'(999)) / wide_t'(1000);
  endfunction

  function automatic wide_t clamp(input wide_t v, input wide_t lo, input wide_t hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  logic [5:0] a_nx;
  logic [2:0] sh_nx;

  for (genvar d = 0; d < 2; d++) begin : g_drv
    logic [NS_W-1:0] s_ns, ac_ns, cy_ns, rc_ns;
    logic [NS_W+1:0] used;
    logic [4:0]      ac_nx, r_nx;
    logic [2:0]      a_q;
    logic [4:0]      ac_q, r_q;

    assign s_ns  = setup_ns[d*NS_W +: NS_W];
    assign ac_ns = active_ns[d*NS_W +: NS_W];
    assign cy_ns = cycle_ns[d*NS_W +: NS_W];
    assign used  = {2'b00, s_ns} + {2'b00, ac_ns};
    assign rc_ns = ({2'b00, cy_ns} > used) ? NS_W'({2'b00, cy_ns} - used) : '0;

    assign a_nx[d*3 +: 3] = present[d] ?
      3'(clamp(ns_to_clk(s_ns, bus_mhz), wide_t'(1), wide_t'(4))) : 3'd1;
    assign ac_nx = present[d] ?
      5'(clamp(ns_to_clk(ac_ns, bus_mhz), wide_t'(1), wide_t'(16))) : 5'd1;
    assign r_nx = present[d] ?
      5'(clamp(ns_to_clk(rc_ns, bus_mhz), wide_t'(2), wide_t'(17))) : 5'd2;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q  <= 3'd1;
        ac_q <= 5'd1;
        r_q  <= 5'd2;
      end else if (start) begin
        a_q  <= a_nx[d*3 +: 3];
        ac_q <= ac_nx;
        r_q  <= r_nx;
      end
    end

    assign addr_clk[d*3 +: 3]   = a_q;
    assign act_clk[d*5 +: 5]    = ac_q;
    assign rec_clk[d*5 +: 5]    = r_q;
    assign cycle_byte[d*8 +: 8] = {4'(ac_q - 5'd1), 4'(r_q - 5'd2)};

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      a_q >= 3'd1 && a_q <= 3'd4); // R4
    AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ac_q >= 5'd1 && ac_q <= 5'd16); // R5
    AST_REC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      r_q >= 5'd2 && r_q <= 5'd17); // R6
    AST_ABSENT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      start && !present[d] |=> a_q == 3'd1 && ac_q == 5'd1 && r_q == 5'd2); // R7
  end

  assign sh_nx = (a_nx[2:0] > a_nx[5:3]) ? a_nx[2:0] : a_nx[5:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      shared_addr <= 3'd1;
    end else begin
      done <= start;
      if (start) shared_addr <= sh_nx;
    end
  end

  AST_SHARED_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    shared_addr >= addr_clk[2:0] && shared_addr >= addr_clk[5:3] &&
    (shared_addr == addr_clk[2:0] || shared_addr == addr_clk[5:3])); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> $stable(addr_clk) && $stable(act_clk) && $stable(rec_clk) &&
                      $stable(shared_addr)); // R10
endmodule

// File: tb/test_pio_clock_conv.sv
`timescale 1ns/1ps
module test_pio_clock_conv;
  localparam int NS_W = 10;
  localparam int MHZ_W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [MHZ_W-1:0] bus_mhz = '0;
  logic [1:0] present = '0;
  logic [NS_W-1:0] s_ns [2];
  logic [NS_W-1:0] a_ns [2];
  logic [NS_W-1:0] c_ns [2];
  logic [2*NS_W-1:0] setup_ns, active_ns, cycle_ns;
  logic done;
  logic [5:0] addr_clk;
  logic [9:0] act_clk, rec_clk;
  logic [15:0] cycle_byte;
  logic [2:0] shared_addr;

  assign setup_ns  = {s_ns[1], s_ns[0]};
  assign active_ns = {a_ns[1], a_ns[0]};
  assign cycle_ns  = {c_ns[1], c_ns[0]};

  always #2 clk = ~clk;

  pio_clock_conv #(.NS_W(NS_W), .MHZ_W(MHZ_W)) i_pio_clock_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz), .present(present),
    .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
    .done(done), .addr_clk(addr_clk), .act_clk(act_clk), .rec_clk(rec_clk),
    .cycle_byte(cycle_byte), .shared_addr(shared_addr));

  int checks = 0;
  int failures = 0;
  bit compare_on = 0;

  int e_done;
  int e_a [2];
  int e_ac [2];
  int e_r [2];
  int e_sh;

  function automatic int cv(int t, int m);
    return (t * m + 999) / 1000;
  endfunction

  function automatic int lim(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: updates at the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done <= 0; e_sh <= 1;
      for (int d = 0; d < 2; d++) begin e_a[d] <= 1; e_ac[d] <= 1; e_r[d] <= 2; end
    end else begin
      e_done <= start ? 1 : 0;
      if (start) begin
        int na [2];
        for (int d = 0; d < 2; d++) begin
          if (present[d]) begin
            int rns;
            rns = int'(c_ns[d]) - int'(s_ns[d]) - int'(a_ns[d]);
            if (rns < 0) rns = 0;
            na[d] = lim(cv(int'(s_ns[d]), int'(bus_mhz)), 1, 4);
            e_ac[d] <= lim(cv(int'(a_ns[d]), int'(bus_mhz)), 1, 16);
            e_r[d]  <= lim(cv(rns, int'(bus_mhz)), 2, 17);
          end else begin
            na[d] = 1; e_ac[d] <= 1; e_r[d] <= 2;
          end
          e_a[d] <= na[d];
        end
        e_sh <= (na[0] > na[1]) ? na[0] : na[1];
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      check("R10 done", int'(done), e_done);
      for (int d = 0; d < 2; d++) begin
        check("R2/R4 addr", int'(addr_clk[d*3 +: 3]), e_a[d]);
        check("R5 active", int'(act_clk[d*5 +: 5]), e_ac[d]);
        check("R3/R6 recovery", int'(rec_clk[d*5 +: 5]), e_r[d]);
        check("R8 byte", int'(cycle_byte[d*8 +: 8]), (e_ac[d] - 1) * 16 + (e_r[d] - 2));
      end
      check("R9 shared", int'(shared_addr), e_sh);
    end
  end

  task automatic set_drv(int d, int s, int a, int c);
    s_ns[d] = NS_W'(s); a_ns[d] = NS_W'(a); c_ns[d] = NS_W'(c);
  endtask

  task automatic pulse;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_drv(0, 0, 0, 0); set_drv(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 addr", int'(addr_clk), 6'o11);
    check("R1 active", int'(act_clk), 10'h021);
    check("R1 recovery", int'(rec_clk), 10'h042);
    check("R1 byte", int'(cycle_byte), 0);
    check("R1 shared", int'(shared_addr), 1);
    compare_on = 1;

    // R2 R3 R8: slow mode at 33 MHz -> 3,6,13, byte 0x5B
    bus_mhz = 33; present = 2'b11;
    set_drv(0, 70, 165, 600); set_drv(1, 30, 80, 180);
    pulse;
    check("R2 addr literal", int'(addr_clk[2:0]), 3);
    check("R3 recovery literal", int'(rec_clk[4:0]), 13);
    check("R8 byte literal", int'(cycle_byte[7:0]), 8'h5B);
    check("R9 shared literal", int'(shared_addr), 3);
    @(negedge clk);

    // R10 hold: inputs change without start
    set_drv(0, 500, 900, 1000); bus_mhz = 200; present = 2'b01;
    repeat (4) @(negedge clk);
    check("R10 held byte", int'(cycle_byte[7:0]), 8'h5B);

    // R7 absent drive 1 with large times, R9 shared picks drive 0
    present = 2'b01; bus_mhz = 40;
    set_drv(0, 70, 290, 600); set_drv(1, 900, 900, 1000);
    pulse;
    check("R7 absent addr", int'(addr_clk[5:3]), 1);
    check("R7 absent active", int'(act_clk[9:5]), 1);
    check("R7 absent recovery", int'(rec_clk[9:5]), 2);
    check("R9 shared absent", int'(shared_addr), 3);

    // R4 R5 R6 upper clamps
    present = 2'b11; bus_mhz = 255;
    set_drv(0, 1000, 1000, 1023); set_drv(1, 10, 900, 1023);
    pulse;
    check("R4 clamp high", int'(addr_clk[2:0]), 4);
    check("R5 clamp high", int'(act_clk[4:0]), 16);
    check("R6 clamp high", int'(rec_clk[9:5]), 17);

    // lower clamps and negative recovery
    bus_mhz = 20;
    set_drv(0, 0, 0, 0); set_drv(1, 100, 200, 250);
    pulse;
    check("R4 clamp low", int'(addr_clk[2:0]), 1);
    check("R5 clamp low", int'(act_clk[4:0]), 1);
    check("R3 negative recovery", int'(rec_clk[9:5]), 2);

    // back-to-back starts
    bus_mhz = 50; set_drv(0, 30, 80, 180);
    start = 1;
    @(negedge clk);
    bus_mhz = 25; set_drv(1, 50, 125, 383);
    @(negedge clk);
    start = 0;
    @(negedge clk);

    // random vectors
    for (int i = 0; i < 300; i++) begin
      bus_mhz = MHZ_W'($urandom_range(255, 1));
      present = 2'($urandom_range(3, 0));
      for (int d = 0; d < 2; d++)
        set_drv(d, $urandom_range(200, 0), $urandom_range(500, 0), $urandom_range(1023, 0));
      if ($urandom_range(3, 0) != 0) start = 1;
      @(negedge clk);
      start = 0;
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule